// File: doc/BRIEF.md
# LCD Pixel Clock Divider

This block turns the core clock into the pixel clock for a display panel. An 8-bit divisor `pcd` sets the rate. The output period is 2×(`pcd`+2) core cycles, with a 50% duty cycle, so each half lasts `pcd`+2 core cycles. The fastest output is core/6 and the slowest is core/514.

The block also gives a one-cycle strobe, `launch`, in the core cycle in which the chosen pixel clock edge occurs. The display data path uses this strobe to change pixel data. A select input picks the edge: rising or falling.

The divisor and the edge select are taken only while `en` is low. While `en` is low, the output stays at its idle low level and the half-period counter is held at zero. A divisor of zero is not legal, and the block runs it as a divisor of one.

Top module: `lcd_pixclk_gen`

## Requirements
- R1: While reset is asserted, `pix_clk` and `launch` are both 0.
- R2: While `en` is 0, `pix_clk` and `launch` are 0 from the next cycle on.
- R3: After `en` rises, the first toggle of `pix_clk` comes at the (`pcd`+2)-th rising core edge with `en` high, because the count restarts from zero on every enable.
- R4: While `en` stays high, `pix_clk` toggles every `pcd`+2 core cycles. The period is 2×(`pcd`+2) cycles and the duty cycle is 50%.
- R5: A captured `pcd` of 0 gives the same output as a `pcd` of 1 (core/6).
- R6: With `edge_sel`=0, `launch` is high for exactly one core cycle: the first cycle in which `pix_clk` reads 1 after a low phase. It is 0 in every other cycle.
- R7: With `edge_sel`=1, `launch` is high for exactly one core cycle: the first cycle in which `pix_clk` reads 0 after a high phase.
- R8: `pcd` and `edge_sel` are sampled in the last cycle before `en` rises. Changes to them while `en` is 1 have no effect on `pix_clk` or `launch`.
- R9: A `pcd` of 255 gives half periods of 257 cycles (core/514).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; configuration is taken while low |
| pcd | input | DIV_W | Divisor; the half period is pcd+2 cycles |
| edge_sel | input | 1 | 0: launch on rising edge, 1: launch on falling edge |
| pix_clk | output | 1 | Pixel clock level, idle low |
| launch | output | 1 | One-cycle strobe on the selected pixel clock edge |

## Verification
The bench builds the block with the default `DIV_W` of 8. This puts both ends of the divisor range within reach: the shortest half period of 3 cycles and the longest of 257. It also covers the zero divisor, which is folded to one.

Each run spans several full pixel periods for both edge selections. Some runs change the divisor and edge select mid-run, so the bench can see that the captured settings stay fixed while the block is enabled.

// File: rtl/lcd_pixclk_gen.sv
module lcd_pixclk_gen #(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] pcd,
  input  logic             edge_sel,
  output logic             pix_clk,
  output logic             launch
);

  logic [DIV_W-1:0] cfg_div;
  logic             cfg_pol;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             wrap;

  assign half_m1 = CNT_W'(cfg_div) + CNT_W'(1);
  assign wrap    = (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_div <= DIV_W'(1);
      cfg_pol <= 1'b0;
      cnt     <= '0;
      pix_clk <= 1'b0;
      launch  <= 1'b0;
    end else if (!en) begin
      cfg_div <= (pcd == '0) ? DIV_W'(1) : pcd;
      cfg_pol <= edge_sel;
      cnt     <= '0;
      pix_clk <= 1'b0;
      launch  <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      pix_clk <= ~pix_clk;
      launch  <= (pix_clk == cfg_pol);
    end else begin
      cnt     <= cnt + CNT_W'(1);
      launch  <= 1'b0;
    end
  end

endmodule

// File: rtl/lcd_pixclk_chk.sv
module lcd_pixclk_chk #(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pix_clk,
  input logic             launch,
  input logic             cfg_pol,
  input logic [DIV_W-1:0] cfg_div,
  input logic [CNT_W-1:0] cnt
);

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pix_clk && !launch));

  // R6
  launch_on_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (pix_clk != $past(pix_clk)));

  // R7
  launch_edge_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (pix_clk == !cfg_pol));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(cfg_div) && $stable(cfg_pol)));

  // R5
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_div != '0);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(cfg_div) + CNT_W'(1));

endmodule

bind lcd_pixclk_gen lcd_pixclk_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pix_clk(pix_clk), .launch(launch),
  .cfg_pol(cfg_pol), .cfg_div(cfg_div), .cnt(cnt)
);

// File: tb/lcd_pixclk_gen_bench.sv
module lcd_pixclk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] pcd = 8'd1;
  logic       edge_sel = 1'b0;
  logic       pix_clk, launch;
  int         n_chk = 0;
  int         n_bad = 0;

  lcd_pixclk_gen #(.DIV_W(8)) u_lcd_pixclk_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .pcd(pcd), .edge_sel(edge_sel),
    .pix_clk(pix_clk), .launch(launch)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic act_p, input logic exp_p,
                       input logic act_l, input logic exp_l, input int cyc);
    n_chk++;
    if (act_p !== exp_p || act_l !== exp_l) begin
      n_bad++;
      $display("FAIL %s cycle %0d: pix_clk=%b launch=%b expected pix_clk=%b launch=%b",
               req, cyc, act_p, act_l, exp_p, exp_l);
    end
  endtask

  task automatic run_case(input int div, input bit pol, input bit disturb, input string req);
    int half;
    logic ep, el;
    half = ((div == 0) ? 1 : div) + 2;
    @(negedge clk);
    en = 1'b0; pcd = div[7:0]; edge_sel = pol;
    @(negedge clk);
    check({req, " R2 idle"}, pix_clk, 1'b0, launch, 1'b0, 0);
    @(negedge clk);
    en = 1'b1;
    for (int n = 1; n <= 4 * half + 1; n++) begin
      @(negedge clk);
      ep = ((n / half) % 2) == 1;
      el = (n % half == 0) && (ep != pol);
      check(req, pix_clk, ep, launch, el, n);
      if (disturb && n == 2) begin
        pcd = 8'd9; edge_sel = ~pol;
      end
    end
    en = 1'b0;
    @(negedge clk);
    check({req, " R2 stop"}, pix_clk, 1'b0, launch, 1'b0, 0);
  endtask

  task automatic reset_case();
    @(negedge clk);
    check("R1 reset", pix_clk, 1'b0, launch, 1'b0, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    reset_case();
    run_case(1, 1'b0, 1'b0, "R3 R4 R6 pcd1");
    run_case(2, 1'b1, 1'b0, "R4 R7 pcd2");
    run_case(0, 1'b0, 1'b0, "R5 pcd0");
    run_case(0, 1'b1, 1'b0, "R5 R7 pcd0");
    run_case(5, 1'b0, 1'b1, "R8 pcd5");
    run_case(6, 1'b1, 1'b1, "R8 R7 pcd6");
    run_case(255, 1'b0, 1'b0, "R9 pcd255");
    run_case(255, 1'b1, 1'b0, "R9 R7 pcd255");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule